// File: doc/BRIEF.md
# Host Port Acknowledge and Request Logic

This block is the external-facing handshake of a 32-bit host port. Inside it are a receive word (loaded by the core and read out by an external device), a transmit word (written by an external device and unloaded by the core) and an interrupt vector word. A single active-low acknowledge input has three uses, and the selected mode picks which one applies. In interrupt mode it places the vector on the data bus. In DMA read mode it places the receive word on the bus. In DMA write mode it captures the bus into the transmit word when the acknowledge is released.

A single active-low request output asks the external device for service. It is always driven and never high-impedance. On the core side, simple one-cycle strobes load the receive word, unload the transmit word and write the vector, and full flags show the state of both data words. The acknowledge input is asynchronous and passes through a synchronizer before it is used. The data bus is shown as an output word with an output enable, so that the pad ring can build the tri-state driver from them.

Top module: `hport_ack`

## Requirements
- R1: During and straight after reset, `req_n_o` is 1, `bus_oe_o` is 0, and `rx_full_o` and `tx_full_o` are both 0.
- R2: `mode_i` is decoded as 2'b00 interrupt, 2'b01 DMA read, 2'b10 DMA write and 2'b11 off. In off mode an acknowledge does nothing: flags and words keep their values, the bus is not driven, and `req_n_o` is 1.
- R3: In interrupt mode, from the second clock edge after `ack_n_i` falls until the second edge after it rises, `bus_oe_o` is 1 and `bus_o` carries the vector word last loaded by `vec_wr_i`.
- R4: In DMA read mode, `bus_oe_o` is 1 over the same window and `bus_o` carries the receive word.
- R5: `bus_oe_o` is 0 outside that acknowledge window in every mode, and it is 0 at all times in DMA write mode and off mode.
- R6: In DMA write mode, on the third clock edge after `ack_n_i` rises, the transmit word takes the value `bus_i` held while the acknowledge was low and `tx_full_o` goes to 1. `bus_i` may change as soon as the acknowledge is released.
- R7: In DMA read mode, on the third clock edge after `ack_n_i` rises, `rx_full_o` goes to 0.
- R8: `req_n_o` is registered. On each edge it is set low if the flags taking effect on that edge call for service under the mode sampled on that edge: in interrupt mode when `irq_i` is 1, in DMA read mode when the receive word is full, and in DMA write mode when the transmit word is empty. Otherwise it is set high. It therefore changes on the same edge as the flag that causes the change.
- R9: If `rx_load_i` falls in the same cycle as a read completion, the new word is stored and `rx_full_o` stays 1.
- R10: If `tx_unload_i` falls in the same cycle as a write capture, the new word is stored and `tx_full_o` stays 1. A write capture while the transmit word is full and not being unloaded is dropped, and the transmit word is unchanged.
- R11: `vec_wr_i` loads `vec_d_i` into the vector word on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Port mode (see R2) |
| irq_i | input | 1 | Core interrupt request level |
| vec_wr_i | input | 1 | Vector word load strobe |
| vec_d_i | input | 32 | Vector word load data |
| rx_load_i | input | 1 | Receive word load strobe |
| rx_d_i | input | 32 | Receive word load data |
| rx_full_o | output | 1 | Receive word holds unread data |
| tx_unload_i | input | 1 | Transmit word unload strobe |
| tx_q_o | output | 32 | Transmit word contents |
| tx_full_o | output | 1 | Transmit word holds unread data |
| ack_n_i | input | 1 | Asynchronous active-low acknowledge |
| bus_i | input | 32 | Data bus input |
| bus_o | output | 32 | Data bus output value |
| bus_oe_o | output | 1 | Data bus output enable |
| req_n_o | output | 1 | Active-low service request |

## Verification
Two pairs of functions can fall in the same cycle. A core load of the receive word can coincide with the completion of an external read, and a core unload of the transmit word can coincide with an external write capture. The bench provokes each pair by pulsing the core strobe in exactly the cycle in which the synchronized release of the acknowledge is seen. It then judges the result by checking that the flag is still full, that the stored word is the new one, and that a following read returns that word through the scoreboard.

// File: rtl/hport_pkg.sv
package hport_pkg;
  typedef enum logic [1:0] {
    HM_IRQ = 2'b00,
    HM_RD  = 2'b01,
    HM_WR  = 2'b10,
    HM_OFF = 2'b11
  } hport_mode_e;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int DW     = 32,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_n_i,
  input  logic [DW-1:0] bus_i,
  output logic          ack_lo_o,
  output logic          rise_o,
  output logic [DW-1:0] hold_o
);
  // sh[SYNC_N-1] is the synchronized level; sh[SYNC_N] is its previous value
  logic [SYNC_N:0]   sh_q, sh_d;
  logic [DW-1:0]     d1_q, hold_q, hold_d;

  always_comb begin
    sh_d   = {sh_q[SYNC_N-1:0], ack_n_i};
    hold_d = hold_q;
    if (!sh_q[0]) hold_d = d1_q;   // bus sample taken alongside a low acknowledge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      d1_q   <= '0;
      hold_q <= '0;
    end else begin
      sh_q   <= sh_d;
      d1_q   <= bus_i;
      hold_q <= hold_d;
    end
  end

  assign ack_lo_o = ~sh_q[SYNC_N-1];
  assign rise_o   = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign hold_o   = hold_q;

  // R6: a release pulse lasts one cycle only
  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hport_regs.sv
module hport_regs
  import hport_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hport_mode_e   mode_i,
  input  logic          rise_i,
  input  logic [DW-1:0] hold_i,
  input  logic          vec_wr_i,
  input  logic [DW-1:0] vec_d_i,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_d_i,
  input  logic          tx_unload_i,
  output logic [DW-1:0] vec_q_o,
  output logic [DW-1:0] rx_q_o,
  output logic [DW-1:0] tx_q_o,
  output logic          rx_full_o,
  output logic          tx_full_o,
  output logic          rx_full_d_o,
  output logic          tx_full_d_o
);
  logic [DW-1:0] vec_q, vec_d, rx_q, rx_d, tx_q, tx_d;
  logic          rx_full_q, rx_full_d, tx_full_q, tx_full_d;
  logic          rd_done, wr_take;

  always_comb begin
    rd_done = rise_i && (mode_i == HM_RD);
    wr_take = rise_i && (mode_i == HM_WR) && (!tx_full_q || tx_unload_i);

    vec_d = vec_q;
    if (vec_wr_i) vec_d = vec_d_i;

    rx_d      = rx_q;
    rx_full_d = rx_full_q;
    if (rd_done) rx_full_d = 1'b0;
    if (rx_load_i) begin          // core load wins over read completion
      rx_d      = rx_d_i;
      rx_full_d = 1'b1;
    end

    tx_d      = tx_q;
    tx_full_d = tx_full_q;
    if (tx_unload_i) tx_full_d = 1'b0;
    if (wr_take) begin            // capture wins over a same-cycle unload
      tx_d      = hold_i;
      tx_full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      rx_full_q <= 1'b0;
      tx_full_q <= 1'b0;
    end else begin
      vec_q     <= vec_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      rx_full_q <= rx_full_d;
      tx_full_q <= tx_full_d;
    end
  end

  assign vec_q_o     = vec_q;
  assign rx_q_o      = rx_q;
  assign tx_q_o      = tx_q;
  assign rx_full_o   = rx_full_q;
  assign tx_full_o   = tx_full_q;
  assign rx_full_d_o = rx_full_d;
  assign tx_full_d_o = tx_full_d;

  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && mode_i == HM_RD && !rx_load_i) |=> !rx_full_q);
  p_rd_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && rx_load_i) |=> (rx_full_q && rx_q == $past(rx_d_i)));
  p_wr_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && mode_i == HM_WR && !tx_full_q) |=> (tx_full_q && tx_q == $past(hold_i)));
  p_wr_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && mode_i == HM_WR && tx_full_q && !tx_unload_i) |=> (tx_full_q && $stable(tx_q)));
endmodule

// File: rtl/hport_bus.sv
module hport_bus
  import hport_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hport_mode_e   mode_i,
  input  logic          ack_lo_i,
  input  logic          irq_i,
  input  logic [DW-1:0] vec_q_i,
  input  logic [DW-1:0] rx_q_i,
  input  logic          rx_full_q_i,
  input  logic          tx_full_q_i,
  input  logic          rx_full_d_i,
  input  logic          tx_full_d_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          req_n_o
);
  logic req_n_q, req_n_d;

  always_comb begin
    unique case (mode_i)
      HM_IRQ:  req_n_d = ~irq_i;
      HM_RD:   req_n_d = ~rx_full_d_i;
      HM_WR:   req_n_d = tx_full_d_i;
      default: req_n_d = 1'b1;
    endcase
    bus_oe_o = ack_lo_i && (mode_i == HM_IRQ || mode_i == HM_RD);
    bus_o    = (mode_i == HM_IRQ) ? vec_q_i : rx_q_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_n_q <= 1'b1;
    else        req_n_q <= req_n_d;
  end

  assign req_n_o = req_n_q;

  p_oe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HM_WR || mode_i == HM_OFF || !ack_lo_i) |-> !bus_oe_o);
  p_req_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HM_RD && $past(mode_i) == HM_RD && rx_full_q_i) |-> !req_n_o);
  p_req_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HM_WR && $past(mode_i) == HM_WR && tx_full_q_i) |-> req_n_o);
  p_req_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == HM_OFF) |-> req_n_o);
endmodule

// File: rtl/hport_ack.sv
module hport_ack
  import hport_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          irq_i,
  input  logic          vec_wr_i,
  input  logic [DW-1:0] vec_d_i,
  input  logic          rx_load_i,
  input  logic [DW-1:0] rx_d_i,
  output logic          rx_full_o,
  input  logic          tx_unload_i,
  output logic [DW-1:0] tx_q_o,
  output logic          tx_full_o,
  input  logic          ack_n_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          req_n_o
);
  hport_mode_e   mode;
  logic          ack_lo, rise, rx_full_d, tx_full_d;
  logic [DW-1:0] hold, vec_q, rx_q;

  assign mode = hport_mode_e'(mode_i);

  hport_sync #(.DW(DW), .SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i), .bus_i(bus_i),
    .ack_lo_o(ack_lo), .rise_o(rise), .hold_o(hold)
  );

  hport_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rise_i(rise), .hold_i(hold),
    .vec_wr_i(vec_wr_i), .vec_d_i(vec_d_i), .rx_load_i(rx_load_i), .rx_d_i(rx_d_i),
    .tx_unload_i(tx_unload_i), .vec_q_o(vec_q), .rx_q_o(rx_q), .tx_q_o(tx_q_o),
    .rx_full_o(rx_full_o), .tx_full_o(tx_full_o),
    .rx_full_d_o(rx_full_d), .tx_full_d_o(tx_full_d)
  );

  hport_bus #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ack_lo_i(ack_lo), .irq_i(irq_i),
    .vec_q_i(vec_q), .rx_q_i(rx_q), .rx_full_q_i(rx_full_o), .tx_full_q_i(tx_full_o),
    .rx_full_d_i(rx_full_d), .tx_full_d_i(tx_full_d),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .req_n_o(req_n_o)
  );
endmodule

// File: tb/hport_ack_tb.sv
module hport_ack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        irq = 1'b0, vec_wr = 1'b0, rx_load = 1'b0, tx_unload = 1'b0;
  logic [31:0] vec_d = '0, rx_d = '0, bus_in = '0;
  logic        ack_n = 1'b1;
  logic        rx_full, tx_full, bus_oe, req_n;
  logic [31:0] tx_q, bus_out;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  hport_ack u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .irq_i(irq),
    .vec_wr_i(vec_wr), .vec_d_i(vec_d), .rx_load_i(rx_load), .rx_d_i(rx_d),
    .rx_full_o(rx_full), .tx_unload_i(tx_unload), .tx_q_o(tx_q), .tx_full_o(tx_full),
    .ack_n_i(ack_n), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(bus_oe), .req_n_o(req_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word at the start of each driven-bus window (R3, R4)
  always @(negedge clk) begin
    if (rst_n && bus_oe && !oe_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R3/R4 unexpected bus drive", bus_out, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(bus_out == e, "R3/R4 bus word", bus_out, e);
      end
    end
    oe_prev = bus_oe;
  end

  // one acknowledge cycle; optional core strobe in the release-detect cycle
  task automatic ack_xfer(input logic [31:0] wd, input int low, input bit do_load,
                          input logic [31:0] ld, input bit do_unl, output bit oe_mid);
    @(negedge clk); ack_n = 1'b0; bus_in = wd;
    repeat (low) @(negedge clk);
    oe_mid = bus_oe;
    ack_n = 1'b1; bus_in = ~wd;
    @(negedge clk);
    check(bus_oe == oe_mid, "R5 oe lags release", {31'b0, bus_oe}, {31'b0, oe_mid});
    @(negedge clk);
    check(!bus_oe, "R5 oe off after window", {31'b0, bus_oe}, 32'h0);
    if (do_load) begin rx_load = 1'b1; rx_d = ld; end
    if (do_unl) tx_unload = 1'b1;
    @(negedge clk);
    rx_load = 1'b0; tx_unload = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit m;
    step(3);
    check(req_n && !bus_oe && !rx_full && !tx_full, "R1 reset state",
          {28'b0, req_n, bus_oe, rx_full, tx_full}, 32'h8);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    check(req_n && !bus_oe && !rx_full && !tx_full, "R1 after release",
          {28'b0, req_n, bus_oe, rx_full, tx_full}, 32'h8);

    // R11 vector load, R8 interrupt request, R3 interrupt acknowledge
    vec_wr = 1'b1; vec_d = 32'hA5A5_0001; mode = 2'b00; irq = 1'b1;
    step(1); vec_wr = 1'b0;
    check(!req_n, "R8 irq request low", {31'b0, req_n}, 32'h0);
    exp_q.push_back(32'hA5A5_0001);  // R11
    ack_xfer(32'h0, 4, 1'b0, 32'h0, 1'b0, m);
    check(m, "R3 oe during irq ack", {31'b0, m}, 32'h1);
    irq = 1'b0; step(1);
    check(req_n, "R8 irq request released", {31'b0, req_n}, 32'h1);

    // R4 DMA read, R7 completion, R8 request, back to back
    mode = 2'b01; rx_load = 1'b1; rx_d = 32'h1111_1111;
    step(1); rx_load = 1'b0;
    check(rx_full && !req_n, "R8 read request with rx full", {30'b0, rx_full, req_n}, 32'h2);
    exp_q.push_back(32'h1111_1111);
    ack_xfer(32'h0, 3, 1'b0, 32'h0, 1'b0, m);
    check(m, "R4 oe during read", {31'b0, m}, 32'h1);
    check(!rx_full && req_n, "R7 rx emptied and request dropped", {30'b0, rx_full, req_n}, 32'h1);
    rx_load = 1'b1; rx_d = 32'h2222_2222; step(1); rx_load = 1'b0;
    exp_q.push_back(32'h2222_2222);
    ack_xfer(32'h0, 3, 1'b0, 32'h0, 1'b0, m);
    rx_load = 1'b1; rx_d = 32'h3333_3333; step(1); rx_load = 1'b0;
    exp_q.push_back(32'h3333_3333);
    ack_xfer(32'h0, 5, 1'b0, 32'h0, 1'b0, m);
    check(!rx_full, "R7 back-to-back read empties", {31'b0, rx_full}, 32'h0);

    // R9 load collides with read completion
    rx_load = 1'b1; rx_d = 32'h4444_4444; step(1); rx_load = 1'b0;
    exp_q.push_back(32'h4444_4444);
    ack_xfer(32'h0, 3, 1'b1, 32'h5555_5555, 1'b0, m);
    check(rx_full && !req_n, "R9 rx stays full after collision", {30'b0, rx_full, req_n}, 32'h2);
    exp_q.push_back(32'h5555_5555);
    ack_xfer(32'h0, 3, 1'b0, 32'h0, 1'b0, m);
    check(!rx_full, "R9 new word read out", {31'b0, rx_full}, 32'h0);

    // R6 DMA write
    mode = 2'b10; step(1);
    check(!req_n, "R8 write request with tx empty", {31'b0, req_n}, 32'h0);
    ack_xfer(32'hCAFE_0001, 4, 1'b0, 32'h0, 1'b0, m);
    check(!m, "R5 no drive in write mode", {31'b0, m}, 32'h0);
    check(tx_full && tx_q == 32'hCAFE_0001, "R6 write captured", tx_q, 32'hCAFE_0001);
    check(req_n, "R8 write request dropped", {31'b0, req_n}, 32'h1);

    // R10 drop while full, then collision with unload
    ack_xfer(32'hDEAD_0002, 3, 1'b0, 32'h0, 1'b0, m);
    check(tx_full && tx_q == 32'hCAFE_0001, "R10 write dropped while full", tx_q, 32'hCAFE_0001);
    ack_xfer(32'hBEEF_0003, 3, 1'b0, 32'h0, 1'b1, m);
    check(tx_full && tx_q == 32'hBEEF_0003, "R10 unload collision keeps new word", tx_q, 32'hBEEF_0003);
    tx_unload = 1'b1; step(1); tx_unload = 1'b0;
    check(!tx_full && !req_n, "R8 unload raises write request", {30'b0, tx_full, req_n}, 32'h0);

    // R2 off mode ignores acknowledge
    mode = 2'b11; rx_load = 1'b1; rx_d = 32'h7777_7777; step(1); rx_load = 1'b0;
    check(req_n, "R2 no request when off", {31'b0, req_n}, 32'h1);
    ack_xfer(32'h1234_5678, 3, 1'b0, 32'h0, 1'b0, m);
    check(!m && rx_full && !tx_full, "R2 off mode ack ignored", {29'b0, m, rx_full, tx_full}, 32'h2);
    mode = 2'b01; step(1);
    check(!req_n, "R2 rx kept while off", {31'b0, req_n}, 32'h0);
    exp_q.push_back(32'h7777_7777);
    ack_xfer(32'h0, 3, 1'b0, 32'h0, 1'b0, m);

    step(2);
    check(exp_q.size() == 0, "R4 all expected words seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule